// File: doc/BRIEF.md
# Predicated Result-Test Write Controller

This block decides, element by element, what a vector loop writes back when a condition test is folded into predication. Each cycle it may accept one element: its predicate mask bit, the computed result, the condition field derived from that result, the element number and the base register numbers of the two destination files. A small set of configuration inputs chooses the behaviour. These are a condition-record flag, a compare-only flag, a selector that picks one bit of the condition field, an invert bit for that bit, and one zeroing flag.

For every accepted element the block produces a write enable, a register index and write data for the result register file. It produces the same three signals for the condition register file. It also raises a flag asking for the element's source operands to be zeroed. An element whose test fails behaves as if its destination predicate bit had been clear from the start. Its condition field is still recorded so that software can examine it later. Elements never influence each other. All outputs are registered one clock after the element is accepted.

Top module: `prt_wb_ctrl`

## Requirements
- R1: An element with predicate bit 0 and zeroing off produces no result write and no condition write. An all-zero mask therefore produces no writes at all.
- R2: An element with predicate bit 1 writes its condition field whenever the record flag or the compare-only flag is set, whether the test passes or fails. The data is the condition field unchanged, and the index is cond base + element number.
- R3: The test selects bit number `cfg_sel` of the 4-bit condition field (bit 0 is the least significant). The test passes when that bit differs from `cfg_inv`, so inv=0 passes on a set bit and inv=1 passes on a clear bit. A passing element with predicate bit 1 and compare-only off writes its result to index result base + element number.
- R4: While compare-only is set, no result write of any kind occurs, including writes of zero.
- R5: With zeroing on and compare-only off, an element that is masked out or fails the test writes zero to its result index. A masked-out element still writes no condition field.
- R6: The single zeroing flag also governs the sources: `out_src_zero` is 1 exactly for an accepted element whose predicate bit is 0 while zeroing is on.
- R7: All outputs follow an accepted element by one clock. A cycle without `in_valid` is followed by a cycle with every write enable and `out_src_zero` low.
- R8: Index sums wrap modulo 2^IDX_W, and write data is 0 whenever its enable is low.
- R9: After synchronous reset every enable is low and all indices and data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An element is presented this cycle |
| in_pred | input | 1 | Predicate mask bit of the element |
| in_result | input | DATA_W | Computed element result |
| in_cond | input | 4 | Condition field derived from the result |
| in_elem | input | IDX_W | Element number within the loop |
| rt_base | input | IDX_W | Base index in the result register file |
| cr_base | input | IDX_W | Base index in the condition register file |
| cfg_rec | input | 1 | Record condition fields |
| cfg_cmp_only | input | 1 | Compare-only: record conditions, never results |
| cfg_sel | input | 2 | Condition bit selected for the test |
| cfg_inv | input | 1 | Test passes when the selected bit differs from this |
| cfg_zero | input | 1 | Zeroing for sources and destination |
| out_res_we | output | 1 | Result register write enable |
| out_res_idx | output | IDX_W | Result register index |
| out_res_data | output | DATA_W | Result write data (zero when zeroing) |
| out_cr_we | output | 1 | Condition register write enable |
| out_cr_idx | output | IDX_W | Condition register index |
| out_cr_data | output | 4 | Condition write data |
| out_src_zero | output | 1 | Zero the element's source operands |

## Verification
The hardest case to reach is an element that has its predicate bit set and fails the test, while zeroing and recording are both on. In that case a condition write and a zero result write must land in the same cycle, at two different indices. The stimulus reaches it by sweeping every selector value with both invert settings over condition fields that hold single bits and their complements. Each sweep runs under every combination of the zeroing, record and compare-only flags. Directed elements near the top of the index range cover wrapping, and a long run of pseudo-random elements mixes all of these back to back.

// File: rtl/prt_pkg.sv
package prt_pkg;

    localparam int CR_W  = 4;
    localparam int SEL_W = $clog2(CR_W);

    typedef struct packed {
        logic             rec;
        logic             cmp_only;
        logic [SEL_W-1:0] sel;
        logic             inv;
        logic             zero;
    } prt_ctrl_t;

    typedef struct packed {
        logic res_we;
        logic res_zero;
        logic cr_we;
        logic src_zero;
    } prt_dec_t;

    function automatic logic prt_test_pass(input logic [CR_W-1:0] cond,
                                           input logic [SEL_W-1:0] sel,
                                           input logic inv);
        return cond[sel] ^ inv;
    endfunction

endpackage

// File: rtl/prt_decide.sv
module prt_decide
    import prt_pkg::*;
(
    input  logic            valid,
    input  logic            pred,
    input  logic [CR_W-1:0] cond,
    input  prt_ctrl_t       ctrl,
    output prt_dec_t        dec
);
    logic pass;
    logic live;
    logic keep;
    logic zap;

    always_comb begin
        pass = prt_test_pass(cond, ctrl.sel, ctrl.inv);
        live = valid & pred;
        keep = live & pass & ~ctrl.cmp_only;
        zap  = valid & ctrl.zero & ~ctrl.cmp_only & (~pred | ~pass);
        dec.cr_we    = live & (ctrl.rec | ctrl.cmp_only);
        dec.res_we   = keep | zap;
        dec.res_zero = zap;
        dec.src_zero = valid & ~pred & ctrl.zero;
    end
endmodule

// File: rtl/prt_index.sv
module prt_index #(
    parameter int IDX_W = 7,
    parameter int LANES = 2
) (
    input  logic [LANES-1:0][IDX_W-1:0] base,
    input  logic [IDX_W-1:0]            offs,
    output logic [LANES-1:0][IDX_W-1:0] idx
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign idx[g] = base[g] + offs;
    end
endmodule

// File: rtl/prt_wb_ctrl.sv
module prt_wb_ctrl
    import prt_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IDX_W  = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_pred,
    input  logic [DATA_W-1:0]  in_result,
    input  logic [CR_W-1:0]    in_cond,
    input  logic [IDX_W-1:0]   in_elem,
    input  logic [IDX_W-1:0]   rt_base,
    input  logic [IDX_W-1:0]   cr_base,
    input  logic               cfg_rec,
    input  logic               cfg_cmp_only,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic               cfg_inv,
    input  logic               cfg_zero,
    output logic               out_res_we,
    output logic [IDX_W-1:0]   out_res_idx,
    output logic [DATA_W-1:0]  out_res_data,
    output logic               out_cr_we,
    output logic [IDX_W-1:0]   out_cr_idx,
    output logic [CR_W-1:0]    out_cr_data,
    output logic               out_src_zero
);
    localparam int LANE_RES = 0;
    localparam int LANE_CR  = 1;

    prt_ctrl_t ctrl;
    prt_dec_t  dec;
    logic [1:0][IDX_W-1:0] bases;
    logic [1:0][IDX_W-1:0] idxs;

    assign ctrl = '{rec: cfg_rec, cmp_only: cfg_cmp_only, sel: cfg_sel,
                    inv: cfg_inv, zero: cfg_zero};
    assign bases[LANE_RES] = rt_base;
    assign bases[LANE_CR]  = cr_base;

    prt_decide u_decide (
        .valid (in_valid),
        .pred  (in_pred),
        .cond  (in_cond),
        .ctrl  (ctrl),
        .dec   (dec)
    );

    prt_index #(.IDX_W(IDX_W), .LANES(2)) u_index (
        .base (bases),
        .offs (in_elem),
        .idx  (idxs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_res_we   <= 1'b0;
            out_res_idx  <= '0;
            out_res_data <= '0;
            out_cr_we    <= 1'b0;
            out_cr_idx   <= '0;
            out_cr_data  <= '0;
            out_src_zero <= 1'b0;
        end else begin
            out_res_we   <= dec.res_we;
            out_res_idx  <= dec.res_we ? idxs[LANE_RES] : '0;
            out_res_data <= (dec.res_we && !dec.res_zero) ? in_result : '0;
            out_cr_we    <= dec.cr_we;
            out_cr_idx   <= dec.cr_we ? idxs[LANE_CR] : '0;
            out_cr_data  <= dec.cr_we ? in_cond : '0;
            out_src_zero <= dec.src_zero;
        end
    end

    // R1: masked-out element never records a condition
    a_r1_masked_no_cr: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_pred) |=> !out_cr_we);
    // R2: recording element always writes its condition field
    a_r2_cr_recorded: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_pred && (cfg_rec || cfg_cmp_only)) |=>
            (out_cr_we && out_cr_data == $past(in_cond)));
    // R4: compare-only never writes a result
    a_r4_cmp_only_quiet: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg_cmp_only) |=> !out_res_we);
    // R5: masked element under zeroing writes zero
    a_r5_zero_masked: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_pred && cfg_zero && !cfg_cmp_only) |=>
            (out_res_we && out_res_data == '0));
    // R7: idle cycle leaves no writes behind
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_res_we && !out_cr_we && !out_src_zero));
endmodule

// File: tb/prt_wb_ctrl_test.sv
module prt_wb_ctrl_test;
    localparam int DW = 64;
    localparam int IW = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 0, in_pred = 0;
    logic [DW-1:0] in_result = '0;
    logic [3:0] in_cond = '0;
    logic [IW-1:0] in_elem = '0, rt_base = '0, cr_base = '0;
    logic cfg_rec = 0, cfg_cmp_only = 0, cfg_inv = 0, cfg_zero = 0;
    logic [1:0] cfg_sel = '0;
    logic out_res_we, out_cr_we, out_src_zero;
    logic [IW-1:0] out_res_idx, out_cr_idx;
    logic [DW-1:0] out_res_data;
    logic [3:0] out_cr_data;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    prt_wb_ctrl #(.DATA_W(DW), .IDX_W(IW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_pred(in_pred),
        .in_result(in_result), .in_cond(in_cond), .in_elem(in_elem),
        .rt_base(rt_base), .cr_base(cr_base), .cfg_rec(cfg_rec),
        .cfg_cmp_only(cfg_cmp_only), .cfg_sel(cfg_sel), .cfg_inv(cfg_inv),
        .cfg_zero(cfg_zero), .out_res_we(out_res_we), .out_res_idx(out_res_idx),
        .out_res_data(out_res_data), .out_cr_we(out_cr_we),
        .out_cr_idx(out_cr_idx), .out_cr_data(out_cr_data),
        .out_src_zero(out_src_zero)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural model: drive one element, then compare one clock later.
    task automatic apply(input bit v, input bit p, input logic [DW-1:0] res,
                         input logic [3:0] cond, input int el, input int rb, input int cb,
                         input bit rec, input bit cmp, input int sel, input bit inv,
                         input bit z);
        bit pass, ewe, ezero, ecr, esz;
        int eidx, ecidx;
        string t;
        in_valid = v; in_pred = p; in_result = res; in_cond = cond;
        in_elem = IW'(el); rt_base = IW'(rb); cr_base = IW'(cb);
        cfg_rec = rec; cfg_cmp_only = cmp; cfg_sel = 2'(sel); cfg_inv = inv; cfg_zero = z;
        pass  = (cond[sel] != inv);
        ecr   = v && p && (rec || cmp);
        ezero = v && z && !cmp && (!p || !pass);
        ewe   = (v && p && pass && !cmp) || ezero;
        esz   = v && !p && z;
        eidx  = (rb + el) % (1 << IW);
        ecidx = (cb + el) % (1 << IW);
        if (!v) t = "R7";
        else if (cmp) t = "R4";
        else if (ezero) t = "R5";
        else if (!p) t = "R1";
        else t = "R3";
        @(negedge clk);
        chk({t, " res_we"}, DW'(out_res_we), DW'(ewe));
        chk({t, " res_idx R8"}, DW'(out_res_idx), ewe ? DW'(eidx) : '0);
        chk({t, " res_data R8"}, out_res_data, (ewe && !ezero) ? res : '0);
        chk(v && p ? "R2 cr_we" : "R1 cr_we", DW'(out_cr_we), DW'(ecr));
        chk("R2 cr_idx", DW'(out_cr_idx), ecr ? DW'(ecidx) : '0);
        chk("R2 cr_data", DW'(out_cr_data), ecr ? DW'(cond) : '0);
        chk("R6 src_zero", DW'(out_src_zero), DW'(esz));
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 res_we", DW'(out_res_we), '0);
        chk("R9 cr_we", DW'(out_cr_we), '0);
        chk("R9 res_data", out_res_data, '0);
        chk("R9 idx", DW'({out_res_idx, out_cr_idx}), '0);
        rst = 1'b0;
        // R1: all-zero mask, zeroing off, with recording on
        for (int i = 0; i < 8; i++)
            apply(1, 0, 64'hDEAD_0000 + DW'(i), 4'hF, i, 10, 40, 1, 0, i % 4, 0, 0);
        // R3/R2/R5/R4: sweep selector, invert, flags
        for (int f = 0; f < 8; f++)
            for (int s = 0; s < 4; s++)
                for (int iv = 0; iv < 2; iv++) begin
                    apply(1, 1, 64'h1234_5678_9ABC_0000 + DW'(s), 4'(1 << s), s, 5, 20,
                          f[0], f[1], s, iv[0], f[2]);
                    apply(1, 1, 64'hFEED_0000 + DW'(s), ~4'(1 << s), s + 4, 5, 20,
                          f[0], f[1], s, iv[0], f[2]);
                    apply(1, 0, 64'hBEEF, 4'h5, s, 5, 20, f[0], f[1], s, iv[0], f[2]);
                end
        // R7: idle gap
        apply(0, 1, 64'h55, 4'hF, 1, 1, 1, 1, 0, 0, 0, 1);
        apply(0, 0, 64'h55, 4'hF, 1, 1, 1, 1, 0, 0, 0, 1);
        // R8: index wraparound
        apply(1, 1, 64'hA5, 4'h1, 3, 126, 127, 1, 0, 0, 0, 0);
        apply(1, 1, 64'hA6, 4'h0, 5, 127, 125, 1, 0, 0, 0, 1);
        // mixed back-to-back elements
        for (int i = 0; i < 300; i++)
            apply($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                  {$urandom, $urandom}, 4'($urandom), $urandom_range(0, 127),
                  $urandom_range(0, 127), $urandom_range(0, 127),
                  $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
                  $urandom_range(0, 3), $urandom_range(0, 1) == 1,
                  $urandom_range(0, 1) == 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule